// File: doc/BRIEF.md
# Run-Time Loop Learning Monitor

This block sits beside a host processor and listens, without driving anything back onto them, to the instruction-fetch address bus and to the separate data-access bus. In its learning phase it looks for a tight loop. A loop shows up as a fetch of a lower address straight after a higher one, where the same branch/target pair comes back on the following iterations. It counts how often that pair repeats. Once the count reaches a threshold supplied at run time, it captures a loop descriptor and stops observing. The descriptor holds the block start and end addresses, the span of operand reads, the lowest write address, the number of iterations seen and a short operation code taken from the instruction word at the loop head.

After capture the block is in its serving phase. Each later fetch of the recorded loop head produces a single-cycle bypass pulse, together with the address at which the host should resume. The host can then skip the loop body while an attached co-processor, which is not part of this block, carries out the work. A synchronous clear discards the descriptor and all learning state and puts the monitor back into learning.

Top module: `loop_observer`

## Requirements
- R1: After reset, learned_o and bypass_o are 0, and every descriptor output (blk_start_o, blk_end_o, opnd_lo_o, opnd_hi_o, dest_o, iter_o, op_o) and resume_addr_o read 0.
- R2: A backward branch is a valid fetch whose address is strictly lower than the address of the previous valid fetch. A fetch of an equal or higher address is never a backward branch.
- R3: A backward branch whose (previous address, current address) pair equals the stored candidate pair increments the repeat count, saturating at 2^CW-1. Any other backward branch replaces the candidate pair and sets the repeat count to 0.
- R4: In learning, a backward branch whose updated repeat count is >= thresh_i captures the descriptor, and learned_o is 1 from the next cycle. The captured fields are: blk_start_o = the current fetch address, blk_end_o = the previous fetch address, iter_o = repeat count + 1, and op_o = fetch_word_i[OPW-1:0] of that fetch. With thresh_i = 0, the first backward branch captures.
- R5: opnd_lo_o and opnd_hi_o are the lowest and highest read addresses (data_valid_i=1, data_we_i=0), and dest_o is the lowest write address (data_we_i=1). Accesses are counted from the cycle in which the current candidate was set, up to and including the capturing cycle. If no read was seen, opnd_lo_o is all ones and opnd_hi_o is 0. If no write was seen, dest_o is all ones.
- R6: While learned_o is 1, no fetch or data activity changes any descriptor output.
- R7: While learned_o is 1, a valid fetch equal to blk_start_o makes bypass_o 1 for exactly the next cycle, with resume_addr_o = blk_end_o during that cycle. At all other times bypass_o is 0 and resume_addr_o is 0.
- R8: clear_i (synchronous, above all other inputs) returns the block to the R1 state on the next cycle and also forgets the previous fetch address and the candidate pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear back to learning |
| thresh_i | input | CW | Repeat count needed to accept a loop |
| fetch_valid_i | input | 1 | Instruction fetch is valid this cycle |
| fetch_addr_i | input | AW | Instruction fetch address |
| fetch_word_i | input | IW | Instruction word returned for the fetch |
| data_valid_i | input | 1 | Data access is valid this cycle |
| data_we_i | input | 1 | Data access is a write |
| data_addr_i | input | AW | Data access address |
| learned_o | output | 1 | Descriptor captured, serving phase |
| blk_start_o | output | AW | Loop head address |
| blk_end_o | output | AW | Address of the backward branch |
| opnd_lo_o | output | AW | Lowest operand read address |
| opnd_hi_o | output | AW | Highest operand read address |
| dest_o | output | AW | Lowest write address |
| iter_o | output | CW+1 | Iterations observed at capture |
| op_o | output | OPW | Operation code from the loop head word |
| bypass_o | output | 1 | One-cycle pulse: skip the loop |
| resume_addr_o | output | AW | Resume address during bypass |

## Verification
All outputs are registered. The descriptor and learned_o change on the rising edge that ends the capturing fetch cycle. bypass_o and resume_addr_o are due one cycle after the fetch of the loop head, and clear takes effect on the next edge. The bench drives every input on the falling edge and advances a cycle-level reference model from the same values. It then compares every output against that model a quarter period after the following rising edge, which is exactly one register stage after the stimulus. Directed sequences pin the counting boundaries, candidate replacement, the tracking window and the width of the bypass pulse. Seeded random loops with noisy data traffic fill in the rest.

// File: rtl/loop_obs_pkg.sv
package loop_obs_pkg;
  typedef enum logic {
    ST_LEARN = 1'b0,
    ST_SERVE = 1'b1
  } obs_state_e;
endpackage

// File: rtl/loop_detect.sv
module loop_detect #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic [CW-1:0] thresh_i,
  output logic          new_cand_o,
  output logic          qualify_o,
  output logic [AW-1:0] branch_addr_o,
  output logic [AW-1:0] target_addr_o,
  output logic [CW:0]   iter_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [AW-1:0] prev_q, cb_q, ct_q;
  logic          prev_v_q, cv_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          back, same;

  always_comb begin
    back  = fetch_valid_i && prev_v_q && (fetch_addr_i < prev_q);
    same  = cv_q && (prev_q == cb_q) && (fetch_addr_i == ct_q);
    cnt_n = same ? ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1) : '0;
    new_cand_o    = en_i && back && !same;
    qualify_o     = en_i && back && (cnt_n >= thresh_i);
    branch_addr_o = prev_q;
    target_addr_o = fetch_addr_i;
    iter_o        = {1'b0, cnt_n} + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0; prev_v_q <= 1'b0;
      cb_q <= '0; ct_q <= '0; cv_q <= 1'b0; cnt_q <= '0;
    end else if (clear_i) begin
      prev_q <= '0; prev_v_q <= 1'b0;
      cb_q <= '0; ct_q <= '0; cv_q <= 1'b0; cnt_q <= '0;
    end else if (en_i) begin
      if (fetch_valid_i) begin
        prev_q   <= fetch_addr_i;
        prev_v_q <= 1'b1;
      end
      if (back) begin
        cb_q  <= prev_q;
        ct_q  <= fetch_addr_i;
        cv_q  <= 1'b1;
        cnt_q <= cnt_n;
      end
    end
  end

  // R3: a replaced candidate starts counting from zero
  a_r3_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_cand_o |=> (cnt_q == '0));
  // R2: only a strictly lower fetch can start or advance a candidate
  a_r2_lower_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && prev_v_q && !(fetch_addr_i < prev_q) && !clear_i)
      |=> ($stable(cb_q) && $stable(ct_q) && $stable(cnt_q)));
endmodule

// File: rtl/range_track.sv
module range_track #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          restart_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] lo_n_o,
  output logic [AW-1:0] hi_n_o,
  output logic [AW-1:0] dst_n_o
);
  logic [AW-1:0] lo_q, hi_q, dst_q, b_lo, b_hi, b_dst;
  logic          seen_q, seen_n;

  always_comb begin
    b_lo   = restart_i ? '1 : lo_q;
    b_hi   = restart_i ? '0 : hi_q;
    b_dst  = restart_i ? '1 : dst_q;
    lo_n_o  = (rd_i && addr_i < b_lo)  ? addr_i : b_lo;
    hi_n_o  = (rd_i && addr_i > b_hi)  ? addr_i : b_hi;
    dst_n_o = (wr_i && addr_i < b_dst) ? addr_i : b_dst;
    seen_n  = rd_i || (seen_q && !restart_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '1; hi_q <= '0; dst_q <= '1; seen_q <= 1'b0;
    end else if (clear_i) begin
      lo_q <= '1; hi_q <= '0; dst_q <= '1; seen_q <= 1'b0;
    end else begin
      lo_q <= lo_n_o; hi_q <= hi_n_o; dst_q <= dst_n_o; seen_q <= seen_n;
    end
  end

  // R5: once any read is tracked, the span is well ordered
  a_r5_span_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (lo_q <= hi_q));
endmodule

// File: rtl/loop_serve.sv
module loop_serve
  import loop_obs_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int IW  = 16,
  parameter int OPW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           qualify_i,
  input  logic [AW-1:0]  branch_addr_i,
  input  logic [AW-1:0]  target_addr_i,
  input  logic [CW:0]    iter_i,
  input  logic [IW-1:0]  fetch_word_i,
  input  logic [AW-1:0]  lo_i,
  input  logic [AW-1:0]  hi_i,
  input  logic [AW-1:0]  dst_i,
  input  logic           fetch_valid_i,
  input  logic [AW-1:0]  fetch_addr_i,
  output logic           learned_o,
  output logic [AW-1:0]  blk_start_o,
  output logic [AW-1:0]  blk_end_o,
  output logic [AW-1:0]  opnd_lo_o,
  output logic [AW-1:0]  opnd_hi_o,
  output logic [AW-1:0]  dest_o,
  output logic [CW:0]    iter_o,
  output logic [OPW-1:0] op_o,
  output logic           bypass_o,
  output logic [AW-1:0]  resume_addr_o
);
  obs_state_e state_q;
  logic       byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LEARN; byp_q <= 1'b0;
      blk_start_o <= '0; blk_end_o <= '0; opnd_lo_o <= '0; opnd_hi_o <= '0;
      dest_o <= '0; iter_o <= '0; op_o <= '0;
    end else if (clear_i) begin
      state_q <= ST_LEARN; byp_q <= 1'b0;
      blk_start_o <= '0; blk_end_o <= '0; opnd_lo_o <= '0; opnd_hi_o <= '0;
      dest_o <= '0; iter_o <= '0; op_o <= '0;
    end else if (state_q == ST_LEARN) begin
      byp_q <= 1'b0;
      if (qualify_i) begin
        state_q     <= ST_SERVE;
        blk_start_o <= target_addr_i;
        blk_end_o   <= branch_addr_i;
        opnd_lo_o   <= lo_i;
        opnd_hi_o   <= hi_i;
        dest_o      <= dst_i;
        iter_o      <= iter_i;
        op_o        <= fetch_word_i[OPW-1:0];
      end
    end else begin
      byp_q <= fetch_valid_i && (fetch_addr_i == blk_start_o);
    end
  end

  assign learned_o     = (state_q == ST_SERVE);
  assign bypass_o      = byp_q;
  assign resume_addr_o = byp_q ? blk_end_o : '0;

  // R7: a bypass is only ever raised while serving
  a_r7_bypass_serving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |-> learned_o);
  // R4: a qualifying branch while learning enters serving
  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!learned_o && qualify_i && !clear_i) |=> learned_o);
  // R6: the descriptor is frozen while serving
  a_r6_desc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (learned_o && !clear_i) |=> ($stable(blk_start_o) && $stable(blk_end_o) &&
      $stable(opnd_lo_o) && $stable(opnd_hi_o) && $stable(dest_o) &&
      $stable(iter_o) && $stable(op_o)));
  // R8: clear drops the descriptor and any bypass
  a_r8_clear_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!learned_o && !bypass_o && blk_start_o == '0));
endmodule

// File: rtl/loop_observer.sv
module loop_observer #(
  parameter int AW  = 16,
  parameter int IW  = 16,
  parameter int CW  = 8,
  parameter int OPW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic [CW-1:0]  thresh_i,
  input  logic           fetch_valid_i,
  input  logic [AW-1:0]  fetch_addr_i,
  input  logic [IW-1:0]  fetch_word_i,
  input  logic           data_valid_i,
  input  logic           data_we_i,
  input  logic [AW-1:0]  data_addr_i,
  output logic           learned_o,
  output logic [AW-1:0]  blk_start_o,
  output logic [AW-1:0]  blk_end_o,
  output logic [AW-1:0]  opnd_lo_o,
  output logic [AW-1:0]  opnd_hi_o,
  output logic [AW-1:0]  dest_o,
  output logic [CW:0]    iter_o,
  output logic [OPW-1:0] op_o,
  output logic           bypass_o,
  output logic [AW-1:0]  resume_addr_o
);
  logic          new_cand, qualify;
  logic [AW-1:0] br_addr, tg_addr, lo_n, hi_n, dst_n;
  logic [CW:0]   iter_n;

  loop_detect #(.AW(AW), .CW(CW)) u_detect (
    .clk_i, .rst_ni, .clear_i,
    .en_i          (!learned_o),
    .fetch_valid_i, .fetch_addr_i, .thresh_i,
    .new_cand_o    (new_cand),
    .qualify_o     (qualify),
    .branch_addr_o (br_addr),
    .target_addr_o (tg_addr),
    .iter_o        (iter_n)
  );

  range_track #(.AW(AW)) u_track (
    .clk_i, .rst_ni, .clear_i,
    .restart_i (new_cand),
    .rd_i      (data_valid_i && !data_we_i),
    .wr_i      (data_valid_i && data_we_i),
    .addr_i    (data_addr_i),
    .lo_n_o    (lo_n),
    .hi_n_o    (hi_n),
    .dst_n_o   (dst_n)
  );

  loop_serve #(.AW(AW), .CW(CW), .IW(IW), .OPW(OPW)) u_serve (
    .clk_i, .rst_ni, .clear_i,
    .qualify_i     (qualify),
    .branch_addr_i (br_addr),
    .target_addr_i (tg_addr),
    .iter_i        (iter_n),
    .fetch_word_i,
    .lo_i (lo_n), .hi_i (hi_n), .dst_i (dst_n),
    .fetch_valid_i, .fetch_addr_i,
    .learned_o, .blk_start_o, .blk_end_o, .opnd_lo_o, .opnd_hi_o, .dest_o,
    .iter_o, .op_o, .bypass_o, .resume_addr_o
  );
endmodule

// File: tb/sim_loop_observer.sv
module sim_loop_observer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0, clear = 1'b0;
  logic [7:0]  thresh = '0;
  logic        fv = 1'b0, dv = 1'b0, dwe = 1'b0;
  logic [15:0] fa = '0, fw = '0, da = '0;
  logic        learned, bypass;
  logic [15:0] bs, be, olo, ohi, dst, res;
  logic [8:0]  iter;
  logic [3:0]  op;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] m_prev, m_cb, m_ct, m_rlo, m_rhi, m_wlo;
  logic        m_pv, m_cv, m_learn, m_byp;
  logic [7:0]  m_cnt;
  logic [15:0] m_bs, m_be, m_lo, m_hi, m_dst;
  logic [8:0]  m_iter;
  logic [3:0]  m_op;

  loop_observer u0 (
    .clk_i(clk), .rst_ni, .clear_i(clear), .thresh_i(thresh),
    .fetch_valid_i(fv), .fetch_addr_i(fa), .fetch_word_i(fw),
    .data_valid_i(dv), .data_we_i(dwe), .data_addr_i(da),
    .learned_o(learned), .blk_start_o(bs), .blk_end_o(be),
    .opnd_lo_o(olo), .opnd_hi_o(ohi), .dest_o(dst), .iter_o(iter),
    .op_o(op), .bypass_o(bypass), .resume_addr_o(res)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] word_of(input logic [15:0] a);
    return a ^ 16'h5A5A;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prev = '0; m_cb = '0; m_ct = '0; m_pv = 0; m_cv = 0; m_cnt = '0;
    m_rlo = '1; m_rhi = '0; m_wlo = '1; m_learn = 0; m_byp = 0;
    m_bs = '0; m_be = '0; m_lo = '0; m_hi = '0; m_dst = '0; m_iter = '0; m_op = '0;
  endtask

  task automatic model_step();
    logic back, same, rst_t;
    logic [7:0]  cn;
    logic [15:0] blo, bhi, bw, nlo, nhi, nw;
    if (clear) begin model_reset(); return; end
    if (m_learn) begin
      m_byp = fv && (fa == m_bs);
      return;
    end
    m_byp = 0;
    back  = fv && m_pv && (fa < m_prev);
    same  = m_cv && (m_prev == m_cb) && (fa == m_ct);
    cn    = same ? ((m_cnt == 8'hFF) ? m_cnt : m_cnt + 8'd1) : 8'd0;
    rst_t = back && !same;
    blo = rst_t ? 16'hFFFF : m_rlo;
    bhi = rst_t ? 16'h0000 : m_rhi;
    bw  = rst_t ? 16'hFFFF : m_wlo;
    nlo = (dv && !dwe && da < blo) ? da : blo;
    nhi = (dv && !dwe && da > bhi) ? da : bhi;
    nw  = (dv && dwe && da < bw) ? da : bw;
    if (back && cn >= thresh) begin
      m_learn = 1; m_bs = fa; m_be = m_prev; m_iter = {1'b0, cn} + 9'd1;
      m_op = fw[3:0]; m_lo = nlo; m_hi = nhi; m_dst = nw;
    end
    if (back) begin m_cb = m_prev; m_ct = fa; m_cv = 1; m_cnt = cn; end
    if (fv) begin m_prev = fa; m_pv = 1; end
    m_rlo = nlo; m_rhi = nhi; m_wlo = nw;
  endtask

  task automatic compare();
    check("R4", "learned", learned, m_learn);
    check("R4", "blk_start", bs, m_bs);
    check("R4", "blk_end", be, m_be);
    check("R4", "iter", iter, m_iter);
    check("R4", "op", op, m_op);
    check("R5", "opnd_lo", olo, m_lo);
    check("R5", "opnd_hi", ohi, m_hi);
    check("R5", "dest", dst, m_dst);
    check("R7", "bypass", bypass, m_byp);
    check("R7", "resume", res, m_byp ? m_be : 16'h0);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit f_v, input logic [15:0] f_a, input bit d_v,
                      input bit d_we, input logic [15:0] d_a, input bit clr);
    fv = f_v; fa = f_a; fw = word_of(f_a); dv = d_v; dwe = d_we; da = d_a; clear = clr;
    model_step();
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare();
    @(negedge clk);
  endtask

  task automatic run_loop(input logic [15:0] base, input int len, input int iters,
                          input bit noise);
    for (int it = 0; it < iters; it++) begin
      for (int k = 0; k < len; k++) begin
        if (noise)
          step(1'b1, base + 16'(k), 1'($urandom % 2), 1'($urandom % 2),
               16'($urandom), 1'b0);
        else if (k == 1)
          step(1'b1, base + 16'(k), 1'b1, 1'b0, 16'h2000 + 16'(it), 1'b0);
        else if (k == 2)
          step(1'b1, base + 16'(k), 1'b1, 1'b1, 16'h3000 + 16'(it), 1'b0);
        else
          step(1'b1, base + 16'(k), 1'b0, 1'b0, 16'h0, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "learned after reset", learned, 0);
    check("R1", "bypass after reset", bypass, 0);
    check("R1", "blk_start after reset", bs, 0);
    check("R1", "resume after reset", res, 0);
    compare();

    // R2: equal and higher fetches never count, even with threshold 0
    thresh = 8'd0;
    step(1, 16'h0050, 0, 0, 0, 0);
    step(1, 16'h0050, 0, 0, 0, 0);
    step(1, 16'h0060, 0, 0, 0, 0);
    check("R2", "no capture on equal/higher fetch", learned, 0);
    step(1, 16'h0040, 0, 0, 0, 0);
    check("R2", "capture on strictly lower fetch", learned, 1);
    check("R4", "thresh0 blk_end", be, 16'h0060);
    check("R4", "thresh0 iter", iter, 1);
    // R8: clear
    step(0, 0, 0, 0, 0, 1);
    check("R8", "learned after clear", learned, 0);
    check("R8", "blk_start after clear", bs, 0);

    // R3: candidate replacement restarts the count
    thresh = 8'd3;
    run_loop(16'h0100, 4, 3, 0);
    run_loop(16'h0200, 3, 4, 0);
    check("R3", "not yet learned after replacement", learned, 0);
    step(1, 16'h0200, 0, 0, 0, 0);
    check("R4", "learned at threshold", learned, 1);
    check("R3", "blk_start of replacing loop", bs, 16'h0200);
    check("R4", "blk_end", be, 16'h0202);
    check("R4", "iter", iter, 4);
    check("R4", "op code", op, 4'hA);
    check("R5", "opnd_lo skips pre-candidate read", olo, 16'h2001);
    check("R5", "opnd_hi", ohi, 16'h2003);
    check("R5", "dest", dst, 16'h3001);

    // R6: activity while serving leaves the descriptor alone
    for (int i = 0; i < 10; i++)
      step(1, (i % 2) ? 16'h04F0 : 16'h0500, 1, 1'(i % 2), 16'h0010, 0);
    check("R6", "blk_start held", bs, 16'h0200);
    check("R6", "opnd_lo held", olo, 16'h2001);
    check("R6", "dest held", dst, 16'h3001);

    // R7: one-cycle bypass with resume address
    step(1, 16'h0200, 0, 0, 0, 0);
    check("R7", "bypass pulse", bypass, 1);
    check("R7", "resume address", res, 16'h0202);
    step(1, 16'h0201, 0, 0, 0, 0);
    check("R7", "bypass drops", bypass, 0);
    check("R7", "resume zero", res, 0);

    // R8: clear wins over a simultaneous head fetch
    step(1, 16'h0200, 0, 0, 0, 1);
    check("R8", "clear over fetch learned", learned, 0);
    check("R8", "clear over fetch bypass", bypass, 0);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      logic [15:0] base;
      int len, its;
      step(0, 0, 0, 0, 0, 1);
      thresh = 8'($urandom % 5);
      base = 16'h0400 + 16'(($urandom % 64) * 8);
      len  = 2 + int'($urandom % 5);
      its  = 1 + int'($urandom % 8);
      if ($urandom % 3 == 0) run_loop(base + 16'h0100, 2, 2, 1);
      run_loop(base, len, its, 1);
      step(1, base + 16'(len), 1'($urandom % 2), 1'($urandom % 2), 16'($urandom), 0);
      for (int i = 0; i < 12; i++)
        step(1'($urandom % 4 != 0), ($urandom % 3 == 0) ? base : base + 16'($urandom % 8),
             1'($urandom % 2), 1'($urandom % 2), 16'($urandom), 0);
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule